// File: doc/BRIEF.md
# Link Error Trend Monitor

This block watches the health of a set of storage links, one port at a time. Each port has four event inputs: CRC error, retry, link reset and speed downshift. Each input is a single-cycle pulse. The block counts each kind of event over fixed windows of clock cycles and compares every window with the one before. It raises an alert only when several kinds of error grow together. A burst of one kind of error alone does not raise an alert.

Every error also drives a recovery ladder for that port. The first request is a retry. If errors keep arriving soon after an action, the next request is a link reset, and after that the path is isolated. A port that stays quiet long enough drops back to the bottom of the ladder. An isolated port stays out of service until software clears it.

Each action, each return to the bottom of the ladder and each new alert produces one log record for that port. The record holds a timestamp, a severity, a snapshot of the four counters, the action and its outcome.

Top module: `link_trend_monitor`

## Requirements
- R1: Each port keeps four separate counts in the current window: CRC, retry, link reset and downshift. Each count saturates at its maximum value. A log record snapshot holds these counts including the cycle being recorded, packed in `log_snap` with CRC in the lowest CNT_W bits, then retry, then link reset, then downshift.
- R2: A window is WIN_LEN cycles long. The first cycle after reset is window cycle 0. In the last cycle of each window, the counts including that cycle become the previous-window counts, and the current counts start again from zero.
- R3: A count type is rising at a window boundary when its count for the ending window is strictly greater than its previous-window count plus `cfg_rise_delta`.
- R4: At a window boundary, `alert` becomes 1 when CRC is rising and at least CORR_MIN of the four types (default 3) are rising. Otherwise `alert` becomes 0. `alert` holds its value until the next boundary. A rise in CRC errors alone never sets `alert`.
- R5: A new alert writes one log record with severity CRIT. An alert that continues across consecutive boundaries writes no further records.
- R6: An error is any event input of a port. An error on a port that is not isolated and has no recovery interval running requests a retry (`act_code` 1) and loads the interval timer with `cfg_esc_interval`.
- R7: An error that arrives while the interval timer is non-zero moves up one step. A retry is followed by a link reset (`act_code` 2, timer reloaded). A link reset is followed by isolate (`act_code` 3). Isolate sets `port_isolated`.
- R8: When the timer counts down to zero with no error, the port returns to the retry step. This writes a record with action 0 and outcome RECOVERED (2).
- R9: While a port is isolated, its errors request no action. `clr_isolate` returns the port to the retry step with the timer idle. `clr_isolate` has no effect on a port that is not isolated.
- R10: Each record gives a severity: INFO 0, WARN 1, CRIT 2. CRIT is used for a new alert or an isolate, WARN for a link reset, and INFO for everything else. It also gives an action (0 none, 1 retry, 2 link reset, 3 isolate) and an outcome (1 pending for retry or link reset, 3 removed for isolate, 2 recovered, 0 for an alert-only record). All outputs appear one cycle after the inputs that cause them.
- R11: `log_ts` is the number of cycles since reset at the cycle that produced the record. The first cycle after reset is numbered 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_crc | input | NPORTS | CRC error pulse per port |
| evt_retry | input | NPORTS | Retry pulse per port |
| evt_linkrst | input | NPORTS | Link reset pulse per port |
| evt_downshift | input | NPORTS | Speed downshift pulse per port |
| cfg_rise_delta | input | CNT_W | Growth margin a count must exceed to be rising |
| cfg_esc_interval | input | INT_W | Cycles after an action during which a new error moves up a step |
| clr_isolate | input | NPORTS | Software clear of an isolated port |
| act_valid | output | NPORTS | Recovery request this cycle |
| act_code | output | NPORTS x 2 | Requested action code |
| port_isolated | output | NPORTS | Port is out of service |
| alert | output | NPORTS | Correlated rising-trend alert level |
| log_valid | output | NPORTS | Log record present for the port |
| log_ts | output | TS_W | Record timestamp |
| log_sev | output | NPORTS x 2 | Record severity |
| log_action | output | NPORTS x 2 | Action taken |
| log_outcome | output | NPORTS x 2 | Outcome of the action |
| log_snap | output | NPORTS x 4*CNT_W | Counter snapshot |

## Verification
The assertions assume that event inputs are synchronous, one bit per cycle for each type and port. They also assume that `clr_isolate` is sampled like any other input, and that the configuration inputs are stable inside a window, so every trend compares windows judged under one margin. The stimulus changes configuration only at segment starts, which fall on window boundaries. It holds each pulse for exactly one cycle and pulses the clear at mid-window, whether or not the port is isolated. This means a clear on a port that is not isolated is also covered.

// File: rtl/ltm_pkg.sv
package ltm_pkg;
    localparam int NTYPES   = 4;
    localparam int T_CRC    = 0;

    localparam logic [1:0] ACT_NONE    = 2'd0;
    localparam logic [1:0] ACT_RETRY   = 2'd1;
    localparam logic [1:0] ACT_RESET   = 2'd2;
    localparam logic [1:0] ACT_ISOLATE = 2'd3;

    localparam logic [1:0] OUT_NONE      = 2'd0;
    localparam logic [1:0] OUT_PENDING   = 2'd1;
    localparam logic [1:0] OUT_RECOVERED = 2'd2;
    localparam logic [1:0] OUT_REMOVED   = 2'd3;

    localparam logic [1:0] SEV_INFO = 2'd0;
    localparam logic [1:0] SEV_WARN = 2'd1;
    localparam logic [1:0] SEV_CRIT = 2'd2;

    typedef enum logic [1:0] {
        LVL_RETRY = 2'd0,
        LVL_RESET = 2'd1,
        LVL_ISO   = 2'd2
    } lvl_e;
endpackage

// File: rtl/ltm_window.sv
module ltm_window #(
    parameter int WIN_LEN = 16,
    parameter int TS_W    = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic            boundary,
    output logic [TS_W-1:0] ts
);
    localparam int WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic [TS_W-1:0]  ts;
    } win_st_t;

    win_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ts = st_q.ts + TS_W'(1);
        if (st_q.win == WIN_LAST) st_d.win = '0;
        else                      st_d.win = st_q.win + WIN_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign boundary = (st_q.win == WIN_LAST);
    assign ts       = st_q.ts;

    // R2: a boundary cycle is never followed directly by another one
    assert_single_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> !boundary);
endmodule

// File: rtl/ltm_port_stats.sv
module ltm_port_stats
    import ltm_pkg::*;
#(
    parameter int CNT_W    = 6,
    parameter int CORR_MIN = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NTYPES-1:0]             evt,
    input  logic                          boundary,
    input  logic [CNT_W-1:0]              delta,
    output logic [NTYPES-1:0][CNT_W-1:0]  snap,
    output logic                          alert,
    output logic                          alert_new
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [NTYPES-1:0][CNT_W-1:0] cur;
        logic [NTYPES-1:0][CNT_W-1:0] prev;
        logic                         alrt;
    } stat_st_t;

    stat_st_t st_d, st_q;
    logic [NTYPES-1:0][CNT_W-1:0] ncur;
    logic [NTYPES-1:0]            rise;
    logic                         cond;

    always_comb begin
        st_d = st_q;
        for (int t = 0; t < NTYPES; t++) begin
            ncur[t] = (st_q.cur[t] == CNT_MAX) ? CNT_MAX
                                               : st_q.cur[t] + CNT_W'(evt[t]);
            rise[t] = {1'b0, ncur[t]} > ({1'b0, st_q.prev[t]} + {1'b0, delta});
        end
        cond      = boundary && rise[T_CRC] && ($countones(rise) >= CORR_MIN);
        alert_new = cond && !st_q.alrt;
        if (boundary) begin
            st_d.prev = ncur;
            st_d.cur  = '0;
            st_d.alrt = cond;
        end else begin
            st_d.cur  = ncur;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign snap  = ncur;
    assign alert = st_q.alrt;

    // R1: inside a window a count never decreases (saturates, no wrap)
    assert_count_no_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> st_q.cur[T_CRC] >= $past(st_q.cur[T_CRC]));
    // R4: alert only changes on a boundary
    assert_alert_on_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.alrt) |-> $past(boundary));
    // R4: an alert needs at least one CRC error in the ending window
    assert_alert_needs_crc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.alrt) |-> $past(snap[T_CRC]) != '0);
endmodule

// File: rtl/ltm_escalator.sv
module ltm_escalator
    import ltm_pkg::*;
#(
    parameter int INT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err,
    input  logic             clr,
    input  logic [INT_W-1:0] interval,
    output logic             act,
    output logic [1:0]       act_code,
    output logic             recovered,
    output logic             isolated
);
    localparam logic [INT_W-1:0] ONE = INT_W'(1);

    typedef struct packed {
        lvl_e             lvl;
        logic [INT_W-1:0] tmr;
    } esc_st_t;

    esc_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        act       = 1'b0;
        act_code  = ACT_NONE;
        recovered = 1'b0;
        if (st_q.lvl == LVL_ISO) begin
            if (clr) begin
                st_d.lvl = LVL_RETRY;
                st_d.tmr = '0;
            end
        end else if (err) begin
            act = 1'b1;
            if (st_q.tmr != '0) begin
                if (st_q.lvl == LVL_RETRY) begin
                    st_d.lvl = LVL_RESET;
                    st_d.tmr = interval;
                    act_code = ACT_RESET;
                end else begin
                    st_d.lvl = LVL_ISO;
                    st_d.tmr = '0;
                    act_code = ACT_ISOLATE;
                end
            end else begin
                st_d.lvl = LVL_RETRY;
                st_d.tmr = interval;
                act_code = ACT_RETRY;
            end
        end else if (st_q.tmr != '0) begin
            st_d.tmr = st_q.tmr - ONE;
            if (st_q.tmr == ONE) begin
                recovered = 1'b1;
                st_d.lvl  = LVL_RETRY;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign isolated = (st_q.lvl == LVL_ISO);

    // R9: isolation is left only through a clear
    assert_isolate_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (isolated && !clr) |=> isolated);
    // R7: isolation is only ever entered from the link-reset step
    assert_isolate_from_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isolated) |-> $past(st_q.lvl) == LVL_RESET);
endmodule

// File: rtl/link_trend_monitor.sv
module link_trend_monitor
    import ltm_pkg::*;
#(
    parameter int NPORTS   = 2,
    parameter int CNT_W    = 6,
    parameter int WIN_LEN  = 16,
    parameter int TS_W     = 16,
    parameter int INT_W    = 4,
    parameter int CORR_MIN = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NPORTS-1:0]                  evt_crc,
    input  logic [NPORTS-1:0]                  evt_retry,
    input  logic [NPORTS-1:0]                  evt_linkrst,
    input  logic [NPORTS-1:0]                  evt_downshift,
    input  logic [CNT_W-1:0]                   cfg_rise_delta,
    input  logic [INT_W-1:0]                   cfg_esc_interval,
    input  logic [NPORTS-1:0]                  clr_isolate,
    output logic [NPORTS-1:0]                  act_valid,
    output logic [NPORTS-1:0][1:0]             act_code,
    output logic [NPORTS-1:0]                  port_isolated,
    output logic [NPORTS-1:0]                  alert,
    output logic [NPORTS-1:0]                  log_valid,
    output logic [TS_W-1:0]                    log_ts,
    output logic [NPORTS-1:0][1:0]             log_sev,
    output logic [NPORTS-1:0][1:0]             log_action,
    output logic [NPORTS-1:0][1:0]             log_outcome,
    output logic [NPORTS-1:0][NTYPES*CNT_W-1:0] log_snap
);
    localparam int SNAP_W = NTYPES * CNT_W;

    typedef struct packed {
        logic [NPORTS-1:0]             act_v;
        logic [NPORTS-1:0][1:0]        act_c;
        logic [NPORTS-1:0]             log_v;
        logic [NPORTS-1:0][1:0]        sev;
        logic [NPORTS-1:0][1:0]        action;
        logic [NPORTS-1:0][1:0]        outcome;
        logic [NPORTS-1:0][SNAP_W-1:0] snap;
        logic [TS_W-1:0]               ts;
    } out_t;

    out_t out_d, out_q;

    logic                                   boundary;
    logic [TS_W-1:0]                        ts;
    logic [NPORTS-1:0][NTYPES-1:0][CNT_W-1:0] stat_snap;
    logic [NPORTS-1:0]                      stat_alert;
    logic [NPORTS-1:0]                      stat_new;
    logic [NPORTS-1:0]                      esc_act;
    logic [NPORTS-1:0][1:0]                 esc_code;
    logic [NPORTS-1:0]                      esc_rec;
    logic [NPORTS-1:0]                      esc_iso;

    ltm_window #(.WIN_LEN(WIN_LEN), .TS_W(TS_W)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (boundary),
        .ts       (ts)
    );

    for (genvar gp = 0; gp < NPORTS; gp++) begin : g_port
        logic [NTYPES-1:0] evt_vec;
        assign evt_vec = {evt_downshift[gp], evt_linkrst[gp], evt_retry[gp], evt_crc[gp]};

        ltm_port_stats #(.CNT_W(CNT_W), .CORR_MIN(CORR_MIN)) u_stats (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt       (evt_vec),
            .boundary  (boundary),
            .delta     (cfg_rise_delta),
            .snap      (stat_snap[gp]),
            .alert     (stat_alert[gp]),
            .alert_new (stat_new[gp])
        );

        ltm_escalator #(.INT_W(INT_W)) u_esc (
            .clk       (clk),
            .rst_n     (rst_n),
            .err       (|evt_vec),
            .clr       (clr_isolate[gp]),
            .interval  (cfg_esc_interval),
            .act       (esc_act[gp]),
            .act_code  (esc_code[gp]),
            .recovered (esc_rec[gp]),
            .isolated  (esc_iso[gp])
        );

        // R6: a request always carries a real action code
        assert_action_coded_R6: assert property (@(posedge clk) disable iff (!rst_n)
            out_q.act_v[gp] |-> out_q.act_c[gp] != ACT_NONE);
        // R7: an isolate request coincides with the port leaving service
        assert_isolate_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (out_q.act_v[gp] && out_q.act_c[gp] == ACT_ISOLATE) |-> esc_iso[gp]);
        // R5: every new alert is logged as critical in the same cycle
        assert_alert_logged_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat_alert[gp]) |-> (out_q.log_v[gp] && out_q.sev[gp] == SEV_CRIT));
        // R8: a recovery record never coincides with an action or isolation
        assert_recovery_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (out_q.log_v[gp] && out_q.outcome[gp] == OUT_RECOVERED)
                |-> (!esc_iso[gp] && !out_q.act_v[gp]));
    end

    always_comb begin
        out_d    = '0;
        out_d.ts = ts;
        for (int p = 0; p < NPORTS; p++) begin
            out_d.act_v[p]  = esc_act[p];
            out_d.act_c[p]  = esc_code[p];
            out_d.log_v[p]  = esc_act[p] || esc_rec[p] || stat_new[p];
            out_d.action[p] = esc_code[p];
            if (esc_act[p])
                out_d.outcome[p] = (esc_code[p] == ACT_ISOLATE) ? OUT_REMOVED : OUT_PENDING;
            else if (esc_rec[p])
                out_d.outcome[p] = OUT_RECOVERED;
            else
                out_d.outcome[p] = OUT_NONE;
            if (stat_new[p] || (esc_code[p] == ACT_ISOLATE))
                out_d.sev[p] = SEV_CRIT;
            else if (esc_code[p] == ACT_RESET)
                out_d.sev[p] = SEV_WARN;
            else
                out_d.sev[p] = SEV_INFO;
            if (out_d.log_v[p])
                out_d.snap[p] = stat_snap[p];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign act_valid     = out_q.act_v;
    assign act_code      = out_q.act_c;
    assign port_isolated = esc_iso;
    assign alert         = stat_alert;
    assign log_valid     = out_q.log_v;
    assign log_ts        = out_q.ts;
    assign log_sev       = out_q.sev;
    assign log_action    = out_q.action;
    assign log_outcome   = out_q.outcome;
    assign log_snap      = out_q.snap;
endmodule

// File: tb/tb_link_trend_monitor.sv
module tb_link_trend_monitor;
    localparam int NP = 2;
    localparam int CW = 6;
    localparam int WL = 16;
    localparam int CMAX = 63;
    localparam int SEG_LEN = 192;
    localparam int NSEG = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0] evt_crc = '0, evt_retry = '0, evt_linkrst = '0, evt_downshift = '0;
    logic [CW-1:0] cfg_rise_delta = '0;
    logic [3:0]    cfg_esc_interval = '0;
    logic [NP-1:0] clr_isolate = '0;
    logic [NP-1:0] act_valid, port_isolated, alert, log_valid;
    logic [NP-1:0][1:0] act_code, log_sev, log_action, log_outcome;
    logic [15:0] log_ts;
    logic [NP-1:0][4*CW-1:0] log_snap;

    always #4 clk = ~clk;

    link_trend_monitor dut (
        .clk(clk), .rst_n(rst_n),
        .evt_crc(evt_crc), .evt_retry(evt_retry), .evt_linkrst(evt_linkrst),
        .evt_downshift(evt_downshift),
        .cfg_rise_delta(cfg_rise_delta), .cfg_esc_interval(cfg_esc_interval),
        .clr_isolate(clr_isolate),
        .act_valid(act_valid), .act_code(act_code), .port_isolated(port_isolated),
        .alert(alert), .log_valid(log_valid), .log_ts(log_ts), .log_sev(log_sev),
        .log_action(log_action), .log_outcome(log_outcome), .log_snap(log_snap)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // model state
    int mcur [NP][4];
    int mprev[NP][4];
    int malrt[NP];
    int mlvl [NP];
    int mtmr [NP];
    int mwin = 0;
    int mts  = 0;
    // expected outputs after the next edge
    int e_actv[NP], e_actc[NP], e_iso[NP], e_alert[NP], e_logv[NP];
    int e_sev[NP], e_action[NP], e_outc[NP], e_snap[NP][4], e_ts;
    int e_bnd;
    int e_crconly;
    int ev[NP][4];
    int clr[NP];
    int dlt, itv;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input string tag, input string what, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic compare();
        for (int p = 0; p < NP; p++) begin
            chk("R6", "act_valid", int'(act_valid[p]), e_actv[p]);
            if (e_actv[p] != 0) chk("R7", "act_code", int'(act_code[p]), e_actc[p]);
            chk("R9", "port_isolated", int'(port_isolated[p]), e_iso[p]);
            chk(e_crconly != 0 ? "R4" : "R3", "alert", int'(alert[p]), e_alert[p]);
            chk(e_outc[p] == 2 ? "R8" : "R5", "log_valid", int'(log_valid[p]), e_logv[p]);
            if (e_logv[p] != 0) begin
                chk("R10", "log_sev", int'(log_sev[p]), e_sev[p]);
                chk("R10", "log_action", int'(log_action[p]), e_action[p]);
                chk("R10", "log_outcome", int'(log_outcome[p]), e_outc[p]);
                chk("R11", "log_ts", int'(log_ts), e_ts);
                for (int t = 0; t < 4; t++)
                    chk(e_bnd != 0 ? "R2" : "R1", "log_snap",
                        int'(log_snap[p][t*CW +: CW]), e_snap[p][t]);
            end
        end
    endtask

    // stimulus for segment s, local cycle i
    task automatic drive(input int s, input int i);
        int w;
        int g;
        int d;
        w = i / WL;
        g = 3 + (s % 4);
        d = 0;
        if (i == 0) begin
            case (s)
                0: begin dlt = 1; itv = 4;  end
                1: begin dlt = 0; itv = 1;  end
                2: begin dlt = 2; itv = 0;  end
                3: begin dlt = 1; itv = 6;  end
                4: begin dlt = 3; itv = 3;  end
                default: begin dlt = 0; itv = 15; end
            endcase
        end
        lfsr = {lfsr[0], lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
        if (w == 3) d = 2;
        if (w == 4) d = 4;
        if (w == 5 || w == 6) d = 7;
        for (int p = 0; p < NP; p++) begin
            clr[p] = (i % WL == 8) ? 1 : 0;
            for (int t = 0; t < 4; t++) begin
                ev[p][t] = 0;
                if (w == 1 && p == 0 && t == 0) ev[p][t] = (i % 2 == 0) ? 1 : 0;
                if (d != 0) ev[p][t] = (((i*5 + t*3 + p*7) % 8) < d) ? 1 : 0;
                if (w == 8 || w == 9) ev[p][t] = ((i % g) == p && ((i / g) % 4) == t) ? 1 : 0;
                if (w == 10) ev[p][t] = int'(lfsr[p*4+t] & lfsr[p*4+t+8]);
            end
        end
        cfg_rise_delta   = CW'(dlt);
        cfg_esc_interval = 4'(itv);
        for (int p = 0; p < NP; p++) begin
            evt_crc[p]       = ev[p][0][0];
            evt_retry[p]     = ev[p][1][0];
            evt_linkrst[p]   = ev[p][2][0];
            evt_downshift[p] = ev[p][3][0];
            clr_isolate[p]   = clr[p][0];
        end
        e_crconly = (w == 1) ? 1 : 0;
    endtask

    task automatic model_step();
        int bnd;
        bnd = (mwin == WL - 1) ? 1 : 0;
        e_bnd = bnd;
        if (bnd == 0) e_crconly = 0;
        e_ts = mts;
        for (int p = 0; p < NP; p++) begin
            int ncur[4];
            int nr;
            int rise0;
            int cond;
            int anew;
            int err;
            int act;
            int code;
            int rec;
            nr = 0;
            rise0 = 0;
            err = 0;
            for (int t = 0; t < 4; t++) begin
                ncur[t] = (mcur[p][t] == CMAX) ? CMAX : mcur[p][t] + ev[p][t];
                if (ncur[t] > mprev[p][t] + dlt) begin
                    nr++;
                    if (t == 0) rise0 = 1;
                end
                if (ev[p][t] != 0) err = 1;
                e_snap[p][t] = ncur[t];
            end
            cond = (bnd != 0 && rise0 != 0 && nr >= 3) ? 1 : 0;
            anew = (cond != 0 && malrt[p] == 0) ? 1 : 0;
            for (int t = 0; t < 4; t++) begin
                if (bnd != 0) begin
                    mprev[p][t] = ncur[t];
                    mcur[p][t]  = 0;
                end else begin
                    mcur[p][t]  = ncur[t];
                end
            end
            if (bnd != 0) malrt[p] = cond;
            act = 0; code = 0; rec = 0;
            if (mlvl[p] == 2) begin
                if (clr[p] != 0) begin mlvl[p] = 0; mtmr[p] = 0; end
            end else if (err != 0) begin
                act = 1;
                if (mtmr[p] != 0) begin
                    if (mlvl[p] == 0) begin mlvl[p] = 1; code = 2; mtmr[p] = itv; end
                    else begin mlvl[p] = 2; code = 3; mtmr[p] = 0; end
                end else begin
                    mlvl[p] = 0; code = 1; mtmr[p] = itv;
                end
            end else if (mtmr[p] != 0) begin
                if (mtmr[p] == 1) begin rec = 1; mlvl[p] = 0; end
                mtmr[p] = mtmr[p] - 1;
            end
            e_actv[p]   = act;
            e_actc[p]   = code;
            e_iso[p]    = (mlvl[p] == 2) ? 1 : 0;
            e_alert[p]  = malrt[p];
            e_logv[p]   = (act != 0 || rec != 0 || anew != 0) ? 1 : 0;
            e_action[p] = code;
            e_outc[p]   = (act != 0) ? ((code == 3) ? 3 : 1) : ((rec != 0) ? 2 : 0);
            e_sev[p]    = (anew != 0 || code == 3) ? 2 : ((code == 2) ? 1 : 0);
        end
        mts  = (mts + 1) % 65536;
        mwin = (mwin + 1) % WL;
    endtask

    initial begin
        for (int p = 0; p < NP; p++) begin
            malrt[p] = 0; mlvl[p] = 0; mtmr[p] = 0;
            e_actv[p] = 0; e_actc[p] = 0; e_iso[p] = 0; e_alert[p] = 0;
            e_logv[p] = 0; e_sev[p] = 0; e_action[p] = 0; e_outc[p] = 0;
            for (int t = 0; t < 4; t++) begin
                mcur[p][t] = 0; mprev[p][t] = 0; e_snap[p][t] = 0;
            end
        end
        e_ts = 0; e_bnd = 0; e_crconly = 0; dlt = 0; itv = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // first compare below checks the reset state of every output
        for (int s = 0; s < NSEG; s++) begin
            for (int i = 0; i < SEG_LEN; i++) begin
                compare();
                drive(s, i);
                model_step();
                @(negedge clk);
            end
        end
        compare();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R11 watchdog: got %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule